// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block sits between the core of a small 8-bit processor and its external bus. The core presents one cycle request at a time: a cycle kind (opcode fetch, data read or data write), an IO-or-memory flag, a 16-bit address and, for writes, a data byte. The controller then runs the cycle on the pins. The low address byte and the data byte share one set of pins, and an address latch strobe in the first clock lets an outside latch capture the low byte. The upper address byte has its own pins and is held for the whole cycle.

A cycle has three clocks: T1 (address), T2 (strobe asserted, ready sampled) and T3 (data completes). While the ready input is low in T2 or in a wait state, the controller adds wait states (TW) and keeps the strobe asserted. Read data is captured from the shared pins at the end of T3 and returned to the core as a one-cycle valid pulse. Between cycles the controller spends one IDLE clock. In IDLE it honours an external hold request: it releases the buses (output enables low) and raises hold acknowledge until hold is removed.

States and transitions: IDLE goes to HOLD when hold is high, otherwise to T1 when a request of a non-zero kind is offered, otherwise it stays. T1 always goes to T2. T2 goes to T3 when ready is high, otherwise to TW. TW goes to T3 when ready is high, otherwise it stays. T3 always goes to IDLE. HOLD stays while hold is high and goes to IDLE when it drops.

Top module: `busctl_top`

## Requirements
- R1: During and straight after reset the controller is in IDLE: `rd_n`=1, `wr_n`=1, `ale`=0, `hlda`=0, `s1s0`=00, `ad_oe`=0, `rd_valid`=0, `req_ready`=1.
- R2: `ale` is 1 only in T1. In T1, `ad_oe`=1 and `ad_out` carries address bits 7:0.
- R3: From T1 through T3 (wait states included), `a_hi` carries address bits 15:8 and `io_m` is 1 for an IO access and 0 for a memory access.
- R4: `s1s0` is 11 for an opcode fetch, 10 for a read and 01 for a write during the whole cycle. It is 00 outside a cycle. The request kind uses the same encoding.
- R5: In a fetch or read cycle, `rd_n` is 0 from T2 through T3, `wr_n` stays 1, and `ad_oe` is 0 after T1.
- R6: In a write cycle, `wr_n` is 0 from T2 through T3, `rd_n` stays 1, and `ad_out` carries the write data with `ad_oe`=1 from T2 through T3.
- R7: `ready` is sampled in T2 and in every wait state. Each sample that sees 0 adds one wait state, and the strobe stays asserted through it. T3 follows the first sample that sees 1.
- R8: In a fetch or read cycle, `ad_in` is captured at the end of T3. In the following clock `rd_valid`=1 and `rd_data` holds the captured byte. `rd_valid` is 0 otherwise.
- R9: A hold request that arrives during a cycle does not cut the cycle short. `hlda` stays 0 until the cycle has passed T3 and one IDLE clock.
- R10: While `hlda`=1, `ad_oe`=0, `bus_oe`=0, `ale`=0 and `req_ready`=0.
- R11: When hold and a request are both present in IDLE, hold wins. After hold drops, `hlda` returns to 0 for one IDLE clock and the pending request then starts T1.
- R12: `req_ready` is 1 only in IDLE with hold low. A request is taken when it is offered with `req_ready`=1. A request of kind 00 is ignored and starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core offers a cycle request |
| req_kind | input | 2 | Cycle kind: 11 fetch, 10 read, 01 write |
| req_io | input | 1 | 1 for an IO access, 0 for memory |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data byte |
| req_ready | output | 1 | Request taken this clock if valid |
| rd_valid | output | 1 | Read data returned this clock |
| rd_data | output | 8 | Captured read data |
| ready | input | 1 | External ready; low inserts wait states |
| hold | input | 1 | External bus master requests the bus |
| hlda | output | 1 | Hold acknowledge |
| ad_out | output | 8 | Shared low address / data byte, driven value |
| ad_oe | output | 1 | Output enable of the shared byte |
| ad_in | input | 8 | Shared low byte as seen on the pins |
| a_hi | output | 8 | Upper address byte |
| bus_oe | output | 1 | Enable for a_hi, io_m, s1s0 and strobes |
| ale | output | 1 | Address latch strobe |
| io_m | output | 1 | IO (1) or memory (0) select |
| s1s0 | output | 2 | Cycle status code |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
Two events can meet in one clock. A hold request can arrive while a cycle is in its wait states, and hold and a new cycle request can both be present in the same IDLE clock. The bench raises hold in T2 of a read that has wait states. It checks that the strobe, the wait count and the captured data are unchanged and that `hlda` appears only after the IDLE clock. It then offers a write request while hold is held. The request must stay untaken with the buses released until hold drops, and then it must start T1 two clocks later with the write status.

// File: rtl/busctl_pkg.sv
package busctl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_TW,
        ST_T3,
        ST_HOLD
    } bus_st_e;

    // Request kind uses the same encoding as the status pins.
    localparam logic [1:0] KIND_NONE  = 2'b00;
    localparam logic [1:0] KIND_WRITE = 2'b01;
    localparam logic [1:0] KIND_READ  = 2'b10;
    localparam logic [1:0] KIND_FETCH = 2'b11;
endpackage

// File: rtl/busctl_fsm.sv
module busctl_fsm
    import busctl_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic          req_io,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          ready,
    input  logic          hold,
    output logic          req_ready,
    output bus_st_e       st,
    output logic [1:0]    cur_kind,
    output logic          cur_io,
    output logic [AW-1:0] cur_addr,
    output logic [DW-1:0] cur_wdata
);
    bus_st_e st_nx;
    logic    take;

    assign req_ready = (st == ST_IDLE) && !hold;
    assign take      = req_ready && req_valid && (req_kind != KIND_NONE);

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (hold)      st_nx = ST_HOLD;
                else if (take) st_nx = ST_T1;
            end
            ST_T1:   st_nx = ST_T2;
            ST_T2:   st_nx = ready ? ST_T3 : ST_TW;
            ST_TW:   st_nx = ready ? ST_T3 : ST_TW;
            ST_T3:   st_nx = ST_IDLE;
            ST_HOLD: st_nx = hold ? ST_HOLD : ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cur_kind  <= KIND_NONE;
            cur_io    <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
        end else begin
            st <= st_nx;
            if (take) begin
                cur_kind  <= req_kind;
                cur_io    <= req_io;
                cur_addr  <= req_addr;
                cur_wdata <= req_wdata;
            end
        end
    end
endmodule

// File: rtl/busctl_outputs.sv
module busctl_outputs
    import busctl_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_st_e       st,
    input  logic [1:0]    cur_kind,
    input  logic          cur_io,
    input  logic [AW-1:0] cur_addr,
    input  logic [DW-1:0] cur_wdata,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic [AW-DW-1:0] a_hi,
    output logic          bus_oe,
    output logic          ale,
    output logic          io_m,
    output logic [1:0]    s1s0,
    output logic          rd_n,
    output logic          wr_n,
    output logic          hlda,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    localparam int HW = AW - DW;

    logic in_cycle, data_ph, is_wr;

    assign in_cycle = (st == ST_T1) || (st == ST_T2) || (st == ST_TW) || (st == ST_T3);
    assign data_ph  = (st == ST_T2) || (st == ST_TW) || (st == ST_T3);
    assign is_wr    = (cur_kind == KIND_WRITE);

    always_comb begin
        ale    = (st == ST_T1);
        hlda   = (st == ST_HOLD);
        bus_oe = (st != ST_HOLD);
        a_hi   = in_cycle ? cur_addr[AW-1:DW] : {HW{1'b0}};
        io_m   = in_cycle && cur_io;
        s1s0   = in_cycle ? cur_kind : KIND_NONE;
        rd_n   = !(data_ph && !is_wr);
        wr_n   = !(data_ph && is_wr);
        ad_oe  = (st == ST_T1) || (data_ph && is_wr);
        if (st == ST_T1)            ad_out = cur_addr[DW-1:0];
        else if (data_ph && is_wr)  ad_out = cur_wdata;
        else                        ad_out = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (st == ST_T3) && !is_wr;
            if ((st == ST_T3) && !is_wr) rd_data <= ad_in;
        end
    end
endmodule

// File: rtl/busctl_top.sv
module busctl_top
    import busctl_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic          req_io,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    input  logic          ready,
    input  logic          hold,
    output logic          hlda,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    input  logic [DW-1:0] ad_in,
    output logic [AW-DW-1:0] a_hi,
    output logic          bus_oe,
    output logic          ale,
    output logic          io_m,
    output logic [1:0]    s1s0,
    output logic          rd_n,
    output logic          wr_n
);
    bus_st_e       st;
    logic [1:0]    cur_kind;
    logic          cur_io;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_wdata;

    busctl_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_io(req_io),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .hold(hold), .req_ready(req_ready),
        .st(st), .cur_kind(cur_kind), .cur_io(cur_io),
        .cur_addr(cur_addr), .cur_wdata(cur_wdata)
    );

    busctl_outputs #(.AW(AW), .DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n), .st(st),
        .cur_kind(cur_kind), .cur_io(cur_io),
        .cur_addr(cur_addr), .cur_wdata(cur_wdata), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .bus_oe(bus_oe),
        .ale(ale), .io_m(io_m), .s1s0(s1s0), .rd_n(rd_n), .wr_n(wr_n),
        .hlda(hlda), .rd_valid(rd_valid), .rd_data(rd_data)
    );
endmodule

// File: rtl/busctl_chk.sv
module busctl_chk
    import busctl_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input bus_st_e       st,
    input logic          ready,
    input logic          ale,
    input logic          ad_oe,
    input logic          bus_oe,
    input logic          hlda,
    input logic          rd_n,
    input logic          wr_n,
    input logic          rd_valid,
    input logic [1:0]    s1s0,
    input logic [AW-DW-1:0] a_hi
);
    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n || wr_n);

    assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && (!rd_n || !wr_n)) |-> $stable(a_hi));

    assert_status_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ale || !rd_n || !wr_n) |-> (s1s0 != 2'b00));

    assert_wait_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_T2 || st == ST_TW) && !ready) |=> (!rd_n || !wr_n));

    assert_rdvalid_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !$past(rd_n));

    assert_hold_after_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda) |-> ($past(rd_n) && $past(wr_n)));

    assert_hold_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!ad_oe && !bus_oe && !ale));
endmodule

bind busctl_top busctl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .ready(ready), .ale(ale),
    .ad_oe(ad_oe), .bus_oe(bus_oe), .hlda(hlda), .rd_n(rd_n), .wr_n(wr_n),
    .rd_valid(rd_valid), .s1s0(s1s0), .a_hi(a_hi)
);

// File: tb/tb_busctl_top.sv
`timescale 1ns/1ps
module tb_busctl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic        req_io = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic        ready = 1'b1;
    logic        hold = 1'b0;
    logic        hlda;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  ad_in = '0;
    logic [7:0]  a_hi;
    logic        bus_oe, ale, io_m, rd_n, wr_n;
    logic [1:0]  s1s0;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    busctl_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .ready(ready), .hold(hold), .hlda(hlda), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .a_hi(a_hi), .bus_oe(bus_oe), .ale(ale), .io_m(io_m),
        .s1s0(s1s0), .rd_n(rd_n), .wr_n(wr_n)
    );

    // kind(2) io(1) addr(16) wdata(8) waits(4) rdata(8)
    localparam int NV = 7;
    localparam logic [38:0] VEC [NV] = '{
        {2'b11, 1'b0, 16'h1234, 8'h00, 4'd0, 8'hA5},
        {2'b10, 1'b0, 16'hFF01, 8'h00, 4'd1, 8'h3C},
        {2'b01, 1'b0, 16'h8000, 8'h5A, 4'd0, 8'h00},
        {2'b10, 1'b1, 16'h0042, 8'h00, 4'd3, 8'hC3},
        {2'b01, 1'b1, 16'h00FE, 8'h81, 4'd2, 8'h00},
        {2'b11, 1'b0, 16'hFFFF, 8'h00, 4'd5, 8'h00},
        {2'b01, 1'b0, 16'h0000, 8'hFF, 4'd1, 8'h00}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic strobes(input logic [1:0] k, input string req);
        if (k == 2'b01) begin
            chk(req, "wr_n low", wr_n, 0);
            chk(req, "rd_n high", rd_n, 1);
        end else begin
            chk(req, "rd_n low", rd_n, 0);
            chk(req, "wr_n high", wr_n, 1);
        end
    endtask

    // Runs one cycle; hold_at_t2 raises hold in T2 to test R9.
    task automatic run_cycle(input logic [1:0] k, input logic io, input logic [15:0] a,
                             input logic [7:0] wd, input int waits, input logic [7:0] rdv,
                             input logic hold_at_t2);
        @(negedge clk);
        req_valid = 1; req_kind = k; req_io = io; req_addr = a; req_wdata = wd;
        ad_in = rdv; ready = 1;
        chk("R12", "req_ready idle", req_ready, 1);
        @(negedge clk); // T1
        req_valid = 0;
        chk("R2", "ale in T1", ale, 1);
        chk("R2", "ad_oe in T1", ad_oe, 1);
        chk("R2", "low address", ad_out, a[7:0]);
        chk("R3", "high address T1", a_hi, a[15:8]);
        chk("R3", "io_m T1", io_m, io);
        chk("R4", "status T1", s1s0, k);
        chk("R5", "no strobe T1", {rd_n, wr_n}, 2'b11);
        ready = (waits == 0);
        @(negedge clk); // T2
        if (hold_at_t2) hold = 1;
        chk("R2", "ale off T2", ale, 0);
        chk("R3", "high address T2", a_hi, a[15:8]);
        chk("R4", "status T2", s1s0, k);
        if (k == 2'b01) begin
            strobes(k, "R6");
            chk("R6", "ad_oe write", ad_oe, 1);
            chk("R6", "write data", ad_out, wd);
        end else begin
            strobes(k, "R5");
            chk("R5", "ad_oe released", ad_oe, 0);
        end
        for (int i = 0; i < waits; i++) begin
            @(negedge clk); // TW
            strobes(k, "R7");
            chk("R3", "io_m in wait", io_m, io);
            chk("R9", "no hlda in cycle", hlda, 0);
            ready = (i == waits - 1);
        end
        @(negedge clk); // T3
        ready = 1;
        strobes(k, "R7");
        chk("R9", "no hlda in T3", hlda, 0);
        if (k == 2'b01) chk("R6", "write data T3", ad_out, wd);
        @(negedge clk); // IDLE
        chk("R7", "strobes released", {rd_n, wr_n}, 2'b11);
        chk("R4", "status idle", s1s0, 2'b00);
        chk("R9", "no hlda in idle", hlda, 0);
        if (k == 2'b01) chk("R8", "no rd_valid on write", rd_valid, 0);
        else begin
            chk("R8", "rd_valid", rd_valid, 1);
            chk("R8", "rd_data", rd_data, rdv);
        end
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "rd_n reset", rd_n, 1);
        chk("R1", "wr_n reset", wr_n, 1);
        chk("R1", "ale reset", ale, 0);
        chk("R1", "hlda reset", hlda, 0);
        chk("R1", "status reset", s1s0, 0);
        chk("R1", "ad_oe reset", ad_oe, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "rd_valid after reset", rd_valid, 0);
        chk("R1", "req_ready after reset", req_ready, 1);

        // Vector table
        for (int v = 0; v < NV; v++)
            run_cycle(VEC[v][38:37], VEC[v][36], VEC[v][35:20], VEC[v][19:12],
                      int'(VEC[v][11:8]), VEC[v][7:0], 1'b0);

        // R12: kind 00 ignored
        @(negedge clk);
        req_valid = 1; req_kind = 2'b00; req_addr = 16'h5555;
        @(negedge clk);
        chk("R12", "kind 00 no ale", ale, 0);
        chk("R12", "kind 00 no status", s1s0, 0);
        req_valid = 0;

        // R9: hold raised in T2 of a read with waits
        run_cycle(2'b10, 1'b0, 16'hABCD, 8'h00, 2, 8'h77, 1'b1);
        // R10/R11: write request offered during hold
        req_valid = 1; req_kind = 2'b01; req_io = 0; req_addr = 16'h2468; req_wdata = 8'h99;
        @(negedge clk); // HOLD
        chk("R10", "hlda", hlda, 1);
        chk("R10", "ad_oe off", ad_oe, 0);
        chk("R10", "bus_oe off", bus_oe, 0);
        chk("R10", "req_ready off", req_ready, 0);
        repeat (3) @(negedge clk);
        chk("R11", "request waits in hold", ale, 0);
        chk("R11", "still held", hlda, 1);
        hold = 0;
        @(negedge clk); // IDLE
        chk("R11", "hlda drops", hlda, 0);
        chk("R11", "req_ready back", req_ready, 1);
        @(negedge clk); // T1
        req_valid = 0;
        chk("R11", "pending starts", ale, 1);
        chk("R11", "pending status", s1s0, 2'b01);
        chk("R11", "pending address", ad_out, 8'h68);
        repeat (3) @(negedge clk); // T2,T3,IDLE
        chk("R11", "pending done", {rd_n, wr_n}, 2'b11);

        // R11: hold and request in the same idle clock
        @(negedge clk);
        hold = 1; req_valid = 1; req_kind = 2'b10; req_addr = 16'h0F0F;
        @(negedge clk);
        chk("R11", "hold wins", hlda, 1);
        chk("R11", "no T1 under hold", ale, 0);
        hold = 0;
        @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        chk("R11", "read starts after hold", ale, 1);
        chk("R11", "read status", s1s0, 2'b10);
        repeat (4) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule